// File: doc/BRIEF.md
# Demand-Triggered Two-Channel Transfer Sequencer

This block decides when each of two transfer channels may move one byte, asks an external byte mover to do it, and keeps each channel's remaining byte count. A channel runs only while its run bit is set. In serial demand mode it reacts to the status flags of a serial port: the receive and transmit flags of the single-byte serial buffer, and the not-empty and not-full flags of the receive and transmit FIFOs. Which flags matter depends on the endpoint kind configured for the channel's source and destination. In pin demand mode each channel follows its own active-low external interrupt pin. That pin can be configured as falling-edge or low-level sensitive.

Every accepted demand becomes exactly one request on a request/acknowledge handshake, and only one request is outstanding at a time. When the acknowledge arrives, the block clears the serial flag that caused the transfer and decrements the count. When the count reaches zero, the block stops the channel and raises its finished flag, which acts as the interrupt request. A configuration write loads the count and the run bit of one channel.

Top module: `dma_demand_seq`

## Requirements
- R1: A transfer request is never raised for a channel whose run bit (`go_o`) is low.
- R2: In serial mode, with endpoint code 1 = serial buffer, 2 = FIFO and 0 = other, a channel demands a transfer when any of these holds: source code 1 and `ri_i`; destination code 1 and `ti_i`; source code 2 and `rfne_i`; destination code 2 and `tfnf_i`. A flag that matches no configured endpoint causes no transfer.
- R3: In the acknowledge cycle, exactly the one flag-clear output belonging to the flag that caused the transfer pulses high for one cycle. No clear output pulses at any other time. One set flag therefore yields exactly one transfer.
- R4: `req_o` stays high with a stable `req_ch_o` until `ack_i` is sampled high, and then drops for at least one cycle.
- R5: Each acknowledged transfer decrements the channel's `count_o` by one.
- R6: An acknowledged transfer that brings the count from 1 to 0 clears `go_o` and sets `done_o` for that channel. `done_o` and `go_o` are never high together.
- R7: In pin mode, `ext_int_ni[i]` drives channel i. With edge sensitivity, each falling edge produces one transfer. Holding the pin low produces no further transfers.
- R8: A falling edge that arrives while a transfer is outstanding is remembered and produces its own transfer afterwards.
- R9: With level sensitivity, transfers repeat while the pin is low and the count is nonzero. The channel finishes per R6.
- R10: When the pin rises in level mode, transfers stop, `go_o` stays set and the count holds. Pulling the pin low again resumes the channel.
- R11: When both channels demand in the same cycle, channel 0 is granted first.
- R12: After reset, no request is raised and all run bits, finished flags and counts are zero. A configuration write (`cfg_we_i`) loads the count and the run bit of channel `cfg_ch_i` and clears its finished flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CH_W | Channel addressed by the write |
| cfg_go_i | input | 1 | Run bit value to load |
| cfg_count_i | input | CNT_W | Byte count to load |
| pin_mode_i | input | NUM_CH | 1 = pin demand mode, 0 = serial demand mode |
| edge_sens_i | input | NUM_CH | In pin mode: 1 = falling edge, 0 = low level |
| src_kind_i | input | NUM_CH x 2 | Source endpoint code per channel |
| dst_kind_i | input | NUM_CH x 2 | Destination endpoint code per channel |
| ri_i | input | 1 | Serial buffer receive flag |
| ti_i | input | 1 | Serial buffer transmit flag |
| rfne_i | input | 1 | Receive FIFO not empty |
| tfnf_i | input | 1 | Transmit FIFO not full |
| ri_clr_o | output | 1 | Clear pulse for the receive flag |
| ti_clr_o | output | 1 | Clear pulse for the transmit flag |
| rfne_clr_o | output | 1 | Clear pulse for the FIFO not-empty flag |
| tfnf_clr_o | output | 1 | Clear pulse for the FIFO not-full flag |
| ext_int_ni | input | NUM_CH | External demand pins, active low, asynchronous |
| req_o | output | 1 | Byte transfer request |
| req_ch_o | output | CH_W | Channel of the request |
| ack_i | input | 1 | Transfer acknowledge |
| go_o | output | NUM_CH | Run bit per channel |
| done_o | output | NUM_CH | Finished flag per channel (interrupt request) |
| count_o | output | NUM_CH x CNT_W | Remaining byte count per channel |

## Verification
A corrupted remembered cause shows up on the first acknowledge as the wrong clear pulse. The bench sees this as a flag that stays set, or as a second transfer from the same flag. A count or run-bit error appears on `count_o` in the cycle after the acknowledge, and at the terminal transfer as a missing or early `done_o`. A lost pending edge or a wrong level-mode stop shows up as a transfer total that differs from the number of edges, or from the time the pin was low, within a few tens of cycles. An inverted priority is visible on the first `req_ch_o` after a simultaneous demand.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    EP_OTHER = 2'd0,
    EP_SBUF  = 2'd1,
    EP_FIFO  = 2'd2
  } ep_kind_e;

  typedef enum logic [2:0] {
    CA_NONE = 3'd0,
    CA_RI   = 3'd1,
    CA_TI   = 3'd2,
    CA_RFNE = 3'd3,
    CA_TFNF = 3'd4,
    CA_PIN  = 3'd5
  } cause_e;
endpackage

// File: rtl/dma_pin_sync.sv
module dma_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic low_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign low_o  = ~sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dma_ch_trig.sv
module dma_ch_trig
  import dma_seq_pkg::*;
(
  input  logic     go_i,
  input  logic     pin_mode_i,
  input  logic     edge_sens_i,
  input  logic [1:0] src_kind_i,
  input  logic [1:0] dst_kind_i,
  input  logic     ri_i,
  input  logic     ti_i,
  input  logic     rfne_i,
  input  logic     tfnf_i,
  input  logic     pin_low_i,
  input  logic     pend_i,
  output logic     trig_o,
  output cause_e   cause_o
);
  always_comb begin
    cause_o = CA_NONE;
    if (go_i) begin
      if (pin_mode_i) begin
        if (edge_sens_i ? pend_i : pin_low_i) cause_o = CA_PIN;
      end else if (src_kind_i == EP_SBUF && ri_i) begin
        cause_o = CA_RI;
      end else if (dst_kind_i == EP_SBUF && ti_i) begin
        cause_o = CA_TI;
      end else if (src_kind_i == EP_FIFO && rfne_i) begin
        cause_o = CA_RFNE;
      end else if (dst_kind_i == EP_FIFO && tfnf_i) begin
        cause_o = CA_TFNF;
      end
    end
  end

  assign trig_o = (cause_o != CA_NONE);
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       trig_i,
  input  cause_e [NUM_CH-1:0]     cause_i,
  input  logic                    ack_i,
  output logic                    req_o,
  output logic [CH_W-1:0]         req_ch_o,
  output logic [NUM_CH-1:0]       grant_o,
  output logic [NUM_CH-1:0]       xfer_done_o,
  output logic [3:0]              flag_clr_o
);
  logic            busy_q;
  logic [CH_W-1:0] ch_q;
  cause_e          cause_q;
  logic [CH_W-1:0] sel_ch;
  logic            any_trig;
  logic            fin;

  // lowest index wins
  always_comb begin
    sel_ch   = '0;
    any_trig = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (trig_i[i]) begin
        sel_ch   = CH_W'(i);
        any_trig = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ch_q    <= '0;
      cause_q <= CA_NONE;
    end else if (!busy_q) begin
      if (any_trig) begin
        busy_q  <= 1'b1;
        ch_q    <= sel_ch;
        cause_q <= cause_i[sel_ch];
      end
    end else if (ack_i) begin
      busy_q  <= 1'b0;
      cause_q <= CA_NONE;
    end
  end

  assign fin      = busy_q & ack_i;
  assign req_o    = busy_q;
  assign req_ch_o = ch_q;

  always_comb begin
    grant_o     = '0;
    xfer_done_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      grant_o[i]     = ~busy_q & any_trig & (sel_ch == CH_W'(i));
      xfer_done_o[i] = fin & (ch_q == CH_W'(i));
    end
  end

  assign flag_clr_o[0] = fin & (cause_q == CA_RI);
  assign flag_clr_o[1] = fin & (cause_q == CA_TI);
  assign flag_clr_o[2] = fin & (cause_q == CA_RFNE);
  assign flag_clr_o[3] = fin & (cause_q == CA_TFNF);
endmodule

// File: rtl/dma_demand_seq.sv
module dma_demand_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [CH_W-1:0]              cfg_ch_i,
  input  logic                         cfg_go_i,
  input  logic [CNT_W-1:0]             cfg_count_i,
  input  logic [NUM_CH-1:0]            pin_mode_i,
  input  logic [NUM_CH-1:0]            edge_sens_i,
  input  logic [NUM_CH-1:0][1:0]       src_kind_i,
  input  logic [NUM_CH-1:0][1:0]       dst_kind_i,
  input  logic                         ri_i,
  input  logic                         ti_i,
  input  logic                         rfne_i,
  input  logic                         tfnf_i,
  output logic                         ri_clr_o,
  output logic                         ti_clr_o,
  output logic                         rfne_clr_o,
  output logic                         tfnf_clr_o,
  input  logic [NUM_CH-1:0]            ext_int_ni,
  output logic                         req_o,
  output logic [CH_W-1:0]              req_ch_o,
  input  logic                         ack_i,
  output logic [NUM_CH-1:0]            go_o,
  output logic [NUM_CH-1:0]            done_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] count_o
);
  logic [NUM_CH-1:0]   trig;
  cause_e [NUM_CH-1:0] cause;
  logic [NUM_CH-1:0]   grant;
  logic [NUM_CH-1:0]   xfer_done;
  logic [NUM_CH-1:0]   pin_low;
  logic [NUM_CH-1:0]   pin_fall;
  logic [NUM_CH-1:0]   pend_q;
  logic [3:0]          flag_clr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_sel;
    assign wr_sel = cfg_we_i && (cfg_ch_i == CH_W'(c));

    dma_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (ext_int_ni[c]),
      .low_o  (pin_low[c]),
      .fall_o (pin_fall[c])
    );

    dma_ch_trig u_trig (
      .go_i        (go_o[c]),
      .pin_mode_i  (pin_mode_i[c]),
      .edge_sens_i (edge_sens_i[c]),
      .src_kind_i  (src_kind_i[c]),
      .dst_kind_i  (dst_kind_i[c]),
      .ri_i        (ri_i),
      .ti_i        (ti_i),
      .rfne_i      (rfne_i),
      .tfnf_i      (tfnf_i),
      .pin_low_i   (pin_low[c]),
      .pend_i      (pend_q[c]),
      .trig_o      (trig[c]),
      .cause_o     (cause[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        count_o[c] <= '0;
        go_o[c]    <= 1'b0;
        done_o[c]  <= 1'b0;
        pend_q[c]  <= 1'b0;
      end else if (wr_sel) begin
        count_o[c] <= cfg_count_i;
        go_o[c]    <= cfg_go_i;
        done_o[c]  <= 1'b0;
        pend_q[c]  <= 1'b0;
      end else begin
        // an edge seen during a transfer stays pending
        pend_q[c] <= (pend_q[c] & ~grant[c])
                   | (pin_fall[c] & go_o[c] & pin_mode_i[c] & edge_sens_i[c]);
        if (xfer_done[c]) begin
          count_o[c] <= count_o[c] - CNT_W'(1);
          if (count_o[c] == CNT_W'(1)) begin
            go_o[c]   <= 1'b0;
            done_o[c] <= 1'b1;
          end
        end
      end
    end
  end

  dma_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .cause_i     (cause),
    .ack_i       (ack_i),
    .req_o       (req_o),
    .req_ch_o    (req_ch_o),
    .grant_o     (grant),
    .xfer_done_o (xfer_done),
    .flag_clr_o  (flag_clr)
  );

  assign ri_clr_o   = flag_clr[0];
  assign ti_clr_o   = flag_clr[1];
  assign rfne_clr_o = flag_clr[2];
  assign tfnf_clr_o = flag_clr[3];
endmodule

// File: rtl/dma_demand_seq_chk.sv
module dma_demand_seq_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cfg_we_i,
  input logic                         ri_clr_o,
  input logic                         ti_clr_o,
  input logic                         rfne_clr_o,
  input logic                         tfnf_clr_o,
  input logic                         req_o,
  input logic [CH_W-1:0]              req_ch_o,
  input logic                         ack_i,
  input logic [NUM_CH-1:0]            go_o,
  input logic [NUM_CH-1:0]            done_o,
  input logic [NUM_CH-1:0][CNT_W-1:0] count_o
);
  // R1
  req_needs_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> go_o[req_ch_o]);

  // R3
  single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ri_clr_o, ti_clr_o, rfne_clr_o, tfnf_clr_o}));

  // R3
  clear_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_clr_o | ti_clr_o | rfne_clr_o | tfnf_clr_o) |-> (req_o && ack_i));

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(req_ch_o)));

  // R4
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    count_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && ack_i && req_ch_o == CH_W'(c) && !cfg_we_i)
      |=> count_o[c] == $past(count_o[c]) - CNT_W'(1));

    // R6
    terminal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && ack_i && req_ch_o == CH_W'(c) && !cfg_we_i && count_o[c] == CNT_W'(1))
      |=> (done_o[c] && !go_o[c]));

    // R6
    done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[c] |-> !go_o[c]);
  end
endmodule

bind dma_demand_seq dma_demand_seq_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .ri_clr_o   (ri_clr_o),
  .ti_clr_o   (ti_clr_o),
  .rfne_clr_o (rfne_clr_o),
  .tfnf_clr_o (tfnf_clr_o),
  .req_o      (req_o),
  .req_ch_o   (req_ch_o),
  .ack_i      (ack_i),
  .go_o       (go_o),
  .done_o     (done_o),
  .count_o    (count_o)
);

// File: tb/dma_demand_seq_tb.sv
`timescale 1ns/1ps
module dma_demand_seq_tb;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic                         cfg_we = 1'b0;
  logic [0:0]                   cfg_ch = '0;
  logic                         cfg_go = 1'b0;
  logic [CNT_W-1:0]             cfg_count = '0;
  logic [NUM_CH-1:0]            pin_mode = '0;
  logic [NUM_CH-1:0]            edge_sens = '0;
  logic [NUM_CH-1:0][1:0]       src_kind = '0;
  logic [NUM_CH-1:0][1:0]       dst_kind = '0;
  logic [NUM_CH-1:0]            ext_n = '1;
  logic                         ack = 1'b0;
  logic                         req;
  logic [0:0]                   req_ch;
  logic [NUM_CH-1:0]            go, done;
  logic [NUM_CH-1:0][CNT_W-1:0] count;
  logic                         ri_clr, ti_clr, rfne_clr, tfnf_clr;

  // flag model: 0 ri, 1 ti, 2 rfne, 3 tfnf
  logic [3:0] flags = '0;
  logic [3:0] flag_set = '0;
  logic [3:0] flag_wipe = '0;

  dma_demand_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_go_i(cfg_go), .cfg_count_i(cfg_count),
    .pin_mode_i(pin_mode), .edge_sens_i(edge_sens),
    .src_kind_i(src_kind), .dst_kind_i(dst_kind),
    .ri_i(flags[0]), .ti_i(flags[1]), .rfne_i(flags[2]), .tfnf_i(flags[3]),
    .ri_clr_o(ri_clr), .ti_clr_o(ti_clr), .rfne_clr_o(rfne_clr), .tfnf_clr_o(tfnf_clr),
    .ext_int_ni(ext_n),
    .req_o(req), .req_ch_o(req_ch), .ack_i(ack),
    .go_o(go), .done_o(done), .count_o(count)
  );

  always @(posedge clk)
    flags <= (flags | flag_set) & ~(flag_wipe | {tfnf_clr, rfne_clr, ti_clr, ri_clr});

  // responder with programmable latency
  int ack_dly = 0;
  int ack_wait = 0;
  always @(negedge clk) begin
    if (req && !ack) begin
      if (ack_wait >= ack_dly) ack = 1'b1;
      else ack_wait = ack_wait + 1;
    end else begin
      ack = 1'b0;
      ack_wait = 0;
    end
  end

  int xfers [NUM_CH];
  initial begin
    xfers[0] = 0;
    xfers[1] = 0;
  end
  always @(posedge clk)
    if (req && ack) xfers[req_ch] = xfers[req_ch] + 1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(input int ch, input int cnt, input bit g);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch[0:0]; cfg_count = cnt[CNT_W-1:0]; cfg_go = g;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_flag(input int f, input bit wipe);
    @(negedge clk);
    if (wipe) flag_wipe[f] = 1'b1; else flag_set[f] = 1'b1;
    @(negedge clk);
    flag_wipe = '0; flag_set = '0;
  endtask

  function automatic bit exp_trig(input int s, input int d, input int f);
    return (f == 0 && s == 1) || (f == 1 && d == 1) || (f == 2 && s == 2) || (f == 3 && d == 2);
  endfunction

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int x0, x1, c, s, d, f, cnt_lvl, seed;
    bit first_seen;
    seed = $urandom(32'd7071);
    cycles(3);
    // R12 reset state
    check(!req && go == 0 && done == 0 && count[0] == 0 && count[1] == 0, "R12 reset", int'(req), 0);
    rst_ni = 1'b1;
    cycles(2);

    // R1: flag set, run bit low
    src_kind[0] = 2'd1;
    cfg_write(0, 4, 1'b0);
    check(count[0] == 4 && go[0] == 0, "R12 load", int'(count[0]), 4);
    pulse_flag(0, 1'b0);
    cycles(20);
    check(xfers[0] == 0 && flags[0], "R1 no run bit", xfers[0], 0);
    pulse_flag(0, 1'b1);

    // R2/R3/R5/R6: serial buffer receive, three bytes
    ack_dly = 1;
    cfg_write(0, 3, 1'b1);
    for (int k = 0; k < 3; k++) begin
      pulse_flag(0, 1'b0);
      cycles(10);
      check(!flags[0], "R3 ri cleared", int'(flags[0]), 0);
      check(count[0] == 3 - (k + 1), "R5 count", int'(count[0]), 3 - (k + 1));
    end
    check(xfers[0] == 3, "R3 one per flag", xfers[0], 3);
    check(done[0] && !go[0], "R6 finished", int'(done[0]), 1);
    cfg_write(0, 2, 1'b1);
    check(!done[0] && go[0], "R12 write clears done", int'(done[0]), 0);
    cfg_write(0, 0, 1'b0);
    src_kind[0] = 2'd0;

    // R2: channel 1 destination FIFO
    dst_kind[1] = 2'd2;
    cfg_write(1, 1, 1'b1);
    pulse_flag(3, 1'b0);
    cycles(10);
    check(xfers[1] == 1 && !flags[3], "R2 tfnf ch1", xfers[1], 1);
    check(done[1] && !go[1] && count[1] == 0, "R6 ch1 finished", int'(count[1]), 0);
    dst_kind[1] = 2'd0;

    // R2/R3 random serial patterns on channel 0
    for (int it = 0; it < 200; it++) begin
      s = $urandom_range(2, 0);
      d = $urandom_range(2, 0);
      f = $urandom_range(3, 0);
      c = $urandom_range(3, 1);
      ack_dly = $urandom_range(3, 0);
      src_kind[0] = s[1:0];
      dst_kind[0] = d[1:0];
      cfg_write(0, c, 1'b1);
      x0 = xfers[0];
      pulse_flag(f, 1'b0);
      cycles(14);
      if (exp_trig(s, d, f)) begin
        check(xfers[0] == x0 + 1 && !flags[f], "R3 random xfer", xfers[0] - x0, 1);
        check(count[0] == c - 1 && done[0] == (c == 1), "R5 random count", int'(count[0]), c - 1);
      end else begin
        check(xfers[0] == x0 && flags[f] && count[0] == c, "R2 random no match", xfers[0] - x0, 0);
        pulse_flag(f, 1'b1);
      end
    end
    cfg_write(0, 0, 1'b0);
    src_kind[0] = 2'd0;
    dst_kind[0] = 2'd0;

    // R7 edge mode on channel 1
    ack_dly = 0;
    pin_mode[1] = 1'b1; edge_sens[1] = 1'b1;
    cfg_write(1, 5, 1'b1);
    x1 = xfers[1];
    for (int k = 0; k < 2; k++) begin
      ext_n[1] = 1'b0; cycles(3);
      ext_n[1] = 1'b1; cycles(8);
    end
    ext_n[1] = 1'b0; cycles(40);
    check(xfers[1] == x1 + 3 && count[1] == 2, "R7 edge count", int'(count[1]), 2);
    ext_n[1] = 1'b1; cycles(6);

    // R8 edge during outstanding transfer
    ack_dly = 15;
    ext_n[1] = 1'b0; cycles(3);
    ext_n[1] = 1'b1; cycles(3);
    ext_n[1] = 1'b0; cycles(3);
    ext_n[1] = 1'b1; cycles(60);
    check(xfers[1] == x1 + 5, "R8 pending edge", xfers[1] - x1, 5);
    check(done[1] && count[1] == 0, "R8 finished", int'(count[1]), 0);
    pin_mode[1] = 1'b0; edge_sens[1] = 1'b0;

    // R9/R10 level mode on channel 0
    ack_dly = 2;
    pin_mode[0] = 1'b1;
    cfg_write(0, 10, 1'b1);
    ext_n[0] = 1'b0;
    for (int k = 0; k < 200 && count[0] > 6; k++) @(negedge clk);
    ext_n[0] = 1'b1;
    cycles(20);
    cnt_lvl = int'(count[0]);
    check(go[0] && cnt_lvl > 0 && cnt_lvl <= 6, "R10 stop keeps run", cnt_lvl, 6);
    cycles(20);
    check(int'(count[0]) == cnt_lvl && go[0], "R10 count holds", int'(count[0]), cnt_lvl);
    ext_n[0] = 1'b0;
    cycles(80);
    check(done[0] && !go[0] && count[0] == 0, "R9 level finish", int'(count[0]), 0);
    ext_n[0] = 1'b1;
    cycles(5);

    // R11 simultaneous demand
    ack_dly = 0;
    pin_mode = 2'b11; edge_sens = 2'b00;
    cfg_write(0, 2, 1'b1);
    cfg_write(1, 2, 1'b1);
    ext_n = 2'b00;
    for (int k = 0; k < 20 && !req; k++) @(negedge clk);
    check(req && req_ch == 0, "R11 first grant", int'(req_ch), 0);
    first_seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (req && req_ch == 1 && !first_seen) begin
        first_seen = 1'b1;
        check(count[0] == 0, "R11 ch0 before ch1", int'(count[0]), 0);
      end
    end
    check(done == 2'b11, "R11 both finished", int'(done), 3);
    ext_n = 2'b11;
    pin_mode = 2'b00;

    cycles(5);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule